// File: doc/BRIEF.md
# Panel Memory Examine and Alter Unit

This unit lets an operator read and change single bytes of main memory from panel switches. The operator sets an address on a bank of address switches and a byte on the data switches. There are two momentary buttons. A press of the examine button reads the addressed byte. The byte enters the bottom of a two-byte window shown on the lower sixteen lights, and the byte that was there before moves up one group. A press of the write button stores the data switch value at the addressed byte and leaves the lights as they are.

Each button passes through a synchroniser and a rising-edge detector, so one press makes one memory access however long the button is held. Accesses use a simple request/acknowledge port. The request stays high with stable address and data until memory returns a one-cycle acknowledge. Presses that arrive while an access is outstanding are dropped.

The light register also has three other jobs. It shows the address field of a halt instruction on the lower lights, unless the examine button is being held. It shows processor error indicators on the top lights in run or instruction mode. It provides a lamp test that lights every lamp and empties the window.

Top module: `panel_mem_port`

## Requirements
- R1: After reset all lights are dark while `run_mode` is 0, and `mem_req` is low.
- R2: An examine press produces a read access at the switch address. On its acknowledge, `mem_rdata` goes to `lights[7:0]`, the previous `lights[7:0]` byte goes to `lights[15:8]`, and the previous upper byte is lost.
- R3: An examine press never writes memory: `mem_we` is 0 for its access.
- R4: A write press produces one access with `mem_we`=1, `mem_addr` equal to the address switches and `mem_wdata` equal to the data switches, all taken at the press. The window and the lights do not change.
- R5: A button held for any number of cycles produces exactly one access.
- R6: While `mem_req` is high and no acknowledge has arrived, `mem_addr`, `mem_we` and `mem_wdata` stay stable and the request stays high. The cycle after the acknowledge, `mem_req` is low.
- R7: An examine or write press made while an access is pending is ignored, and no second access follows.
- R8: If both buttons rise in the same cycle, only the examine read is performed and the write is dropped. This is the default setting `EXAMINE_FIRST`=1.
- R9: While `halt_valid` is 1 and the synchronised examine button is released, `lights[15:0]` shows `halt_field`. While the examine button is held, the window is shown instead, even if the halt arrives during the hold.
- R10: When the lamp test is off, `lights[19:16]` equals `err_ind` while `run_mode` is 1 and is 0 otherwise.
- R11: While `lamp_test` is 1 all 20 lights are lit. The lamp test also clears the window, so afterwards `lights[15:0]` reads 0 until the next examine.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| addr_sw | input | ADDR_W | Address switches, up = 1 |
| data_sw | input | DATA_W | Data entry switches |
| exam_btn | input | 1 | Momentary examine button, raw |
| write_btn | input | 1 | Momentary write button, raw |
| lamp_test | input | 1 | Processor-clear lamp test, active high |
| run_mode | input | 1 | Processor in run or instruction mode |
| err_ind | input | ERR_W | Error indicators for the top lights |
| halt_valid | input | 1 | A halt instruction has stopped the processor |
| halt_field | input | 2*DATA_W | Address field of the halt instruction |
| mem_req | output | 1 | Memory access request |
| mem_we | output | 1 | 1 = write, 0 = read |
| mem_addr | output | ADDR_W | Access address |
| mem_wdata | output | DATA_W | Write data |
| mem_ack | input | 1 | One-cycle acknowledge |
| mem_rdata | input | DATA_W | Read data, valid with `mem_ack` |
| lights | output | 2*DATA_W+ERR_W | Light register drive, 1 = lit |

## Verification
Two pairs of functions can fall in the same cycle. The first pair is the two button edges: the bench presses both buttons on the same clock. It judges the result by one request, no write and a one-byte shift of the expected window. The second pair is the halt display and a manual examine: the bench raises `halt_valid` while the examine button is held and the read completes. It expects the window, not the halt field, and expects the halt field back three cycles after release. A read acknowledge that lands during the lamp test is also allowed for: the clear wins, and the checker's shift property is written to exclude that cycle.

// File: rtl/pmp_pkg.sv
package pmp_pkg;
   typedef enum logic [1:0] {
      ACC_IDLE  = 2'd0,
      ACC_READ  = 2'd1,
      ACC_WRITE = 2'd2
   } acc_kind_e;
endpackage

// File: rtl/pmp_btn_sync.sv
module pmp_btn_sync #(
   parameter int STAGES = 2
) (
   input  logic clk,
   input  logic rst_n,
   input  logic btn_raw,
   output logic btn_level,
   output logic btn_rise
);
   if (STAGES < 2) begin : g_bad_stages
      $error("pmp_btn_sync: STAGES must be at least 2");
   end

   logic [STAGES-1:0] chain_q;
   logic              last_q;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         chain_q <= '0;
         last_q  <= 1'b0;
      end else begin
         chain_q <= {chain_q[STAGES-2:0], btn_raw};
         last_q  <= chain_q[STAGES-1];
      end
   end

   assign btn_level = chain_q[STAGES-1];
   assign btn_rise  = chain_q[STAGES-1] & ~last_q;
endmodule

// File: rtl/pmp_req_ctrl.sv
module pmp_req_ctrl
   import pmp_pkg::*;
#(
   parameter int ADDR_W        = 15,
   parameter int DATA_W        = 8,
   parameter bit EXAMINE_FIRST = 1'b1
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              exam_rise,
   input  logic              write_rise,
   input  logic [ADDR_W-1:0] addr_sw,
   input  logic [DATA_W-1:0] data_sw,
   input  logic              mem_ack,
   output logic              mem_req,
   output logic              mem_we,
   output logic [ADDR_W-1:0] mem_addr,
   output logic [DATA_W-1:0] mem_wdata,
   output logic              rd_done
);
   acc_kind_e         kind_q;
   acc_kind_e         pick;
   logic [ADDR_W-1:0] addr_q;
   logic [DATA_W-1:0] wdata_q;

   if (EXAMINE_FIRST) begin : g_exam_first
      always_comb begin
         if (exam_rise)       pick = ACC_READ;
         else if (write_rise) pick = ACC_WRITE;
         else                 pick = ACC_IDLE;
      end
   end else begin : g_write_first
      always_comb begin
         if (write_rise)      pick = ACC_WRITE;
         else if (exam_rise)  pick = ACC_READ;
         else                 pick = ACC_IDLE;
      end
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         kind_q  <= ACC_IDLE;
         addr_q  <= '0;
         wdata_q <= '0;
      end else if (kind_q == ACC_IDLE) begin
         if (pick != ACC_IDLE) begin
            kind_q  <= pick;
            addr_q  <= addr_sw;
            wdata_q <= data_sw;
         end
      end else if (mem_ack) begin
         kind_q <= ACC_IDLE;
      end
   end

   assign mem_req   = (kind_q != ACC_IDLE);
   assign mem_we    = (kind_q == ACC_WRITE);
   assign mem_addr  = addr_q;
   assign mem_wdata = wdata_q;
   assign rd_done   = (kind_q == ACC_READ) & mem_ack;
endmodule

// File: rtl/pmp_light_reg.sv
module pmp_light_reg #(
   parameter int DATA_W = 8,
   parameter int ERR_W  = 4
) (
   input  logic                      clk,
   input  logic                      rst_n,
   input  logic                      rd_done,
   input  logic [DATA_W-1:0]         rd_data,
   input  logic                      lamp_test,
   input  logic                      run_mode,
   input  logic [ERR_W-1:0]          err_ind,
   input  logic                      halt_valid,
   input  logic [2*DATA_W-1:0]       halt_field,
   input  logic                      exam_level,
   output logic [2*DATA_W-1:0]       win,
   output logic [2*DATA_W+ERR_W-1:0] lights
);
   localparam int WIN_W   = 2 * DATA_W;
   localparam int LIGHT_W = WIN_W + ERR_W;

   logic [WIN_W-1:0] win_q;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)        win_q <= '0;
      else if (lamp_test) win_q <= '0;
      else if (rd_done)   win_q <= {win_q[DATA_W-1:0], rd_data};
   end

   always_comb begin
      if (lamp_test) begin
         lights = {LIGHT_W{1'b1}};
      end else begin
         lights[LIGHT_W-1:WIN_W] = run_mode ? err_ind : '0;
         lights[WIN_W-1:0]       = (halt_valid && !exam_level) ? halt_field : win_q;
      end
   end

   assign win = win_q;
endmodule

// File: rtl/panel_mem_port.sv
module panel_mem_port #(
   parameter int ADDR_W        = 15,
   parameter int DATA_W        = 8,
   parameter int ERR_W         = 4,
   parameter int SYNC_STAGES   = 2,
   parameter bit EXAMINE_FIRST = 1'b1
) (
   input  logic                      clk,
   input  logic                      rst_n,
   input  logic [ADDR_W-1:0]         addr_sw,
   input  logic [DATA_W-1:0]         data_sw,
   input  logic                      exam_btn,
   input  logic                      write_btn,
   input  logic                      lamp_test,
   input  logic                      run_mode,
   input  logic [ERR_W-1:0]          err_ind,
   input  logic                      halt_valid,
   input  logic [2*DATA_W-1:0]       halt_field,
   output logic                      mem_req,
   output logic                      mem_we,
   output logic [ADDR_W-1:0]         mem_addr,
   output logic [DATA_W-1:0]         mem_wdata,
   input  logic                      mem_ack,
   input  logic [DATA_W-1:0]         mem_rdata,
   output logic [2*DATA_W+ERR_W-1:0] lights
);
   localparam int WIN_W = 2 * DATA_W;

   if (ADDR_W < 1 || ADDR_W > 32) begin : g_bad_addr
      $error("panel_mem_port: ADDR_W out of range");
   end
   if (DATA_W < 1 || ERR_W < 1) begin : g_bad_width
      $error("panel_mem_port: DATA_W and ERR_W must be positive");
   end

   logic             exam_level, exam_rise;
   logic             write_level, write_rise;
   logic             rd_done;
   logic [WIN_W-1:0] win_q;

   pmp_btn_sync #(.STAGES(SYNC_STAGES)) u_exam_sync (
      .clk(clk), .rst_n(rst_n), .btn_raw(exam_btn),
      .btn_level(exam_level), .btn_rise(exam_rise)
   );

   pmp_btn_sync #(.STAGES(SYNC_STAGES)) u_write_sync (
      .clk(clk), .rst_n(rst_n), .btn_raw(write_btn),
      .btn_level(write_level), .btn_rise(write_rise)
   );

   pmp_req_ctrl #(
      .ADDR_W(ADDR_W), .DATA_W(DATA_W), .EXAMINE_FIRST(EXAMINE_FIRST)
   ) u_ctrl (
      .clk(clk), .rst_n(rst_n),
      .exam_rise(exam_rise), .write_rise(write_rise & write_level),
      .addr_sw(addr_sw), .data_sw(data_sw), .mem_ack(mem_ack),
      .mem_req(mem_req), .mem_we(mem_we), .mem_addr(mem_addr),
      .mem_wdata(mem_wdata), .rd_done(rd_done)
   );

   pmp_light_reg #(.DATA_W(DATA_W), .ERR_W(ERR_W)) u_lights (
      .clk(clk), .rst_n(rst_n),
      .rd_done(rd_done), .rd_data(mem_rdata),
      .lamp_test(lamp_test), .run_mode(run_mode), .err_ind(err_ind),
      .halt_valid(halt_valid), .halt_field(halt_field),
      .exam_level(exam_level), .win(win_q), .lights(lights)
   );
endmodule

// File: rtl/pmp_checker.sv
module pmp_checker #(
   parameter int ADDR_W = 15,
   parameter int DATA_W = 8,
   parameter int ERR_W  = 4
) (
   input logic                      clk,
   input logic                      rst_n,
   input logic                      mem_req,
   input logic                      mem_we,
   input logic [ADDR_W-1:0]         mem_addr,
   input logic [DATA_W-1:0]         mem_wdata,
   input logic                      mem_ack,
   input logic [DATA_W-1:0]         mem_rdata,
   input logic                      lamp_test,
   input logic                      run_mode,
   input logic [ERR_W-1:0]          err_ind,
   input logic [2*DATA_W+ERR_W-1:0] lights,
   input logic [2*DATA_W-1:0]       win_q
);
   localparam int WIN_W = 2 * DATA_W;

   // R6
   req_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (mem_req && !mem_ack) |=> (mem_req && $stable(mem_addr) &&
                                 $stable(mem_we) && $stable(mem_wdata)));

   // R6
   req_drop_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (mem_req && mem_ack) |=> !mem_req);

   // R2
   win_shift_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (mem_req && mem_ack && !mem_we && !lamp_test) |=>
      (win_q == {$past(win_q[DATA_W-1:0]), $past(mem_rdata)}));

   // R4
   alter_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (mem_req && mem_ack && mem_we && !lamp_test) |=> $stable(win_q));

   // R11
   lamp_all_chk: assert property (@(posedge clk) disable iff (!rst_n)
      lamp_test |-> (&lights));

   // R10
   err_lights_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (!lamp_test && run_mode) |-> (lights[WIN_W+ERR_W-1:WIN_W] == err_ind));
endmodule

bind panel_mem_port pmp_checker #(
   .ADDR_W(ADDR_W), .DATA_W(DATA_W), .ERR_W(ERR_W)
) u_pmp_checker (
   .clk(clk), .rst_n(rst_n), .mem_req(mem_req), .mem_we(mem_we),
   .mem_addr(mem_addr), .mem_wdata(mem_wdata), .mem_ack(mem_ack),
   .mem_rdata(mem_rdata), .lamp_test(lamp_test), .run_mode(run_mode),
   .err_ind(err_ind), .lights(lights), .win_q(win_q)
);

// File: tb/sim_panel_mem_port.sv
`timescale 1ns/1ps
module sim_panel_mem_port;
   localparam int AW = 6;
   localparam int DW = 8;
   localparam int EW = 4;
   localparam int DEPTH = 1 << AW;

   logic          clk = 1'b0;
   logic          rst_n = 1'b0;
   logic [AW-1:0] addr_sw = '0;
   logic [DW-1:0] data_sw = '0;
   logic          exam_btn = 1'b0, write_btn = 1'b0;
   logic          lamp_test = 1'b0, run_mode = 1'b0;
   logic [EW-1:0] err_ind = '0;
   logic          halt_valid = 1'b0;
   logic [15:0]   halt_field = '0;
   logic          mem_req, mem_we;
   logic [AW-1:0] mem_addr;
   logic [DW-1:0] mem_wdata;
   logic          mem_ack = 1'b0;
   logic [DW-1:0] mem_rdata = '0;
   logic [19:0]   lights;

   int vectors = 0, misses = 0;
   int req_cnt = 0, wr_cnt = 0, lat = 0, wait_cnt = 0;
   bit seen = 0, done = 0;
   logic [AW-1:0] first_addr;
   logic [DW-1:0] last_wdata;
   logic [AW-1:0] last_waddr;
   logic [DW-1:0] bmem [DEPTH];
   logic [15:0]   exp_win = '0;

   always #10 clk = ~clk;

   panel_mem_port #(.ADDR_W(AW), .DATA_W(DW), .ERR_W(EW)) u0 (
      .clk(clk), .rst_n(rst_n), .addr_sw(addr_sw), .data_sw(data_sw),
      .exam_btn(exam_btn), .write_btn(write_btn), .lamp_test(lamp_test),
      .run_mode(run_mode), .err_ind(err_ind), .halt_valid(halt_valid),
      .halt_field(halt_field), .mem_req(mem_req), .mem_we(mem_we),
      .mem_addr(mem_addr), .mem_wdata(mem_wdata), .mem_ack(mem_ack),
      .mem_rdata(mem_rdata), .lights(lights)
   );

   task automatic chk(input bit ok, input string req, input logic [31:0] act,
                      input logic [31:0] exp);
      vectors++;
      if (!ok) begin
         misses++;
         $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
      end
   endtask

   // memory model, driven away from the rising edge
   always @(negedge clk) begin
      if (!rst_n) begin
         mem_ack = 1'b0; seen = 0; wait_cnt = 0;
      end else if (mem_ack) begin
         mem_ack = 1'b0; seen = 0;
         chk(mem_req == 1'b0, "R6 req drop", 32'(mem_req), 0);
      end else if (mem_req) begin
         if (!seen) begin
            seen = 1; req_cnt++; first_addr = mem_addr; wait_cnt = 0;
         end else begin
            chk(mem_addr == first_addr, "R6 addr stable", 32'(mem_addr), 32'(first_addr));
         end
         if (wait_cnt >= lat) begin
            mem_ack = 1'b1;
            mem_rdata = bmem[mem_addr];
            if (mem_we) begin
               bmem[mem_addr] = mem_wdata; wr_cnt++;
               last_waddr = mem_addr; last_wdata = mem_wdata;
            end
         end else begin
            wait_cnt++;
         end
      end
   end

   task automatic press(input bit ex, input bit wr, input int hold);
      @(negedge clk);
      exam_btn = ex; write_btn = wr;
      repeat (hold) @(negedge clk);
      exam_btn = 1'b0; write_btn = 1'b0;
      repeat (lat + 12) @(negedge clk);
   endtask

   task automatic finish_run();
      if (!done) begin
         done = 1;
         $display("  == %0d vectors applied, %0d miscompares ==", vectors, misses);
         $finish;
      end
   endtask

   initial begin
      repeat (150000) @(posedge clk);
      misses++;
      $display("FAIL watchdog R1..R11 run hung actual=%0d expected=%0d", 150000, 0);
      finish_run();
   end

   initial begin
      int rc, wc;
      for (int a = 0; a < DEPTH; a++) bmem[a] = 8'((a * 29 + 3) & 255);
      repeat (3) @(negedge clk);
      // R1 reset state
      chk(lights == 20'h0, "R1 lights", 32'(lights), 0);
      chk(mem_req == 1'b0, "R1 req", 32'(mem_req), 0);
      rst_n = 1'b1;
      repeat (2) @(negedge clk);
      chk(lights == 20'h0, "R1 lights after release", 32'(lights), 0);

      // R2 R3 R5: examine sweep over every address
      for (int a = 0; a < DEPTH; a++) begin
         lat = a % 4;
         addr_sw = AW'(a);
         rc = req_cnt; wc = wr_cnt;
         press(1'b1, 1'b0, 2 + (a % 7) * 5);
         exp_win = {exp_win[7:0], bmem[a]};
         chk(lights[15:0] == exp_win, "R2 window", 32'(lights[15:0]), 32'(exp_win));
         chk(req_cnt == rc + 1, "R5 one access", 32'(req_cnt - rc), 1);
         chk(wr_cnt == wc, "R3 no write", 32'(wr_cnt - wc), 0);
      end

      // R4: write sweep, lights untouched
      for (int a = 0; a < DEPTH; a++) begin
         lat = (a * 3) % 5;
         addr_sw = AW'(a);
         data_sw = 8'((a * 53 + 17) & 255);
         wc = wr_cnt;
         press(1'b0, 1'b1, 3);
         chk(wr_cnt == wc + 1, "R4 one write", 32'(wr_cnt - wc), 1);
         chk(last_waddr == AW'(a), "R4 address", 32'(last_waddr), 32'(a));
         chk(last_wdata == 8'((a * 53 + 17) & 255), "R4 data", 32'(last_wdata),
             32'((a * 53 + 17) & 255));
         chk(lights[15:0] == exp_win, "R4 lights quiet", 32'(lights[15:0]), 32'(exp_win));
      end
      // read back a few written bytes
      for (int a = 0; a < DEPTH; a += 9) begin
         lat = 1;
         addr_sw = AW'(a);
         press(1'b1, 1'b0, 3);
         exp_win = {exp_win[7:0], 8'((a * 53 + 17) & 255)};
         chk(lights[15:0] == exp_win, "R4 readback", 32'(lights[15:0]), 32'(exp_win));
      end

      // R7: press during a long pending access
      lat = 20;
      addr_sw = 6'd5;
      rc = req_cnt; wc = wr_cnt;
      @(negedge clk); exam_btn = 1'b1;
      repeat (3) @(negedge clk); exam_btn = 1'b0;
      repeat (4) @(negedge clk); write_btn = 1'b1;
      repeat (3) @(negedge clk); write_btn = 1'b0;
      repeat (4) @(negedge clk); exam_btn = 1'b1;
      repeat (3) @(negedge clk); exam_btn = 1'b0;
      repeat (40) @(negedge clk);
      exp_win = {exp_win[7:0], bmem[5]};
      chk(req_cnt == rc + 1, "R7 one access", 32'(req_cnt - rc), 1);
      chk(wr_cnt == wc, "R7 write dropped", 32'(wr_cnt - wc), 0);
      chk(lights[15:0] == exp_win, "R7 window", 32'(lights[15:0]), 32'(exp_win));

      // R8: both buttons in the same cycle
      lat = 2;
      addr_sw = 6'd33; data_sw = 8'h5A;
      rc = req_cnt; wc = wr_cnt;
      press(1'b1, 1'b1, 4);
      exp_win = {exp_win[7:0], bmem[33]};
      chk(req_cnt == rc + 1, "R8 one access", 32'(req_cnt - rc), 1);
      chk(wr_cnt == wc, "R8 write dropped", 32'(wr_cnt - wc), 0);
      chk(lights[15:0] == exp_win, "R8 window", 32'(lights[15:0]), 32'(exp_win));

      // R9: halt field versus a held examine button
      lat = 0;
      halt_field = 16'hA5C3; halt_valid = 1'b1;
      @(negedge clk);
      chk(lights[15:0] == 16'hA5C3, "R9 halt shown", 32'(lights[15:0]), 32'hA5C3);
      halt_valid = 1'b0;
      addr_sw = 6'd12;
      exam_btn = 1'b1;
      repeat (6) @(negedge clk);
      halt_valid = 1'b1;
      repeat (10) @(negedge clk);
      exp_win = {exp_win[7:0], bmem[12]};
      chk(lights[15:0] == exp_win, "R9 halt blocked", 32'(lights[15:0]), 32'(exp_win));
      exam_btn = 1'b0;
      repeat (3) @(negedge clk);
      chk(lights[15:0] == 16'hA5C3, "R9 halt after release", 32'(lights[15:0]), 32'hA5C3);
      halt_valid = 1'b0;
      @(negedge clk);

      // R10: error group
      for (int e = 0; e < 16; e++) begin
         err_ind = 4'(e); run_mode = 1'b1;
         @(negedge clk);
         chk(lights[19:16] == 4'(e), "R10 run", 32'(lights[19:16]), 32'(e));
         run_mode = 1'b0;
         @(negedge clk);
         chk(lights[19:16] == 4'h0, "R10 idle", 32'(lights[19:16]), 0);
      end

      // R11: lamp test
      lamp_test = 1'b1;
      repeat (2) @(negedge clk);
      chk(lights == 20'hFFFFF, "R11 all lit", 32'(lights), 32'hFFFFF);
      lamp_test = 1'b0;
      @(negedge clk);
      exp_win = '0;
      chk(lights[15:0] == exp_win, "R11 window cleared", 32'(lights[15:0]), 0);
      lat = 1; addr_sw = 6'd40;
      press(1'b1, 1'b0, 3);
      exp_win = {8'h00, bmem[40]};
      chk(lights[15:0] == exp_win, "R11 after clear", 32'(lights[15:0]), 32'(exp_win));

      finish_run();
   end
endmodule